// File: doc/BRIEF.md
# Paged PHY Register File

This block holds the software-visible configuration and status space of a multi-port serial bus physical layer. The link side sees sixteen byte-wide addresses. The lower eight are fixed base registers. The upper eight form a window, and a page number held in base register 7 chooses what the window shows. A read returns data combinationally from the address in the same cycle. A write lands on the next rising clock edge. Fields that are read-only or reserved ignore writes.

Hardware reset loads defaults, and some of those come from strap inputs. Bus-reset events arriving from the arbitration logic act on a different set of fields. Some fields are cleared by a bus reset and others are kept. The gap count returns to its default once two bus resets have occurred back to back with no write to the gap count between them. Root, cable power, physical ID and per-port status are computed elsewhere and only shown here.

Top module: `phy_regfile`

## Requirements
- R1: While `rst_n` is low, the block loads these values: gap count 3Fh; the long-reset request, short-reset request, root-holdoff, resume-interrupt enable and page select all 0; link-active 1; contender equal to `strap_contender`; power class equal to `strap_pwr_class`.
- R2: The readable layout is as follows. Address 0 = {phys_id[5:0], root, cable_pwr}. Address 1 = {root-holdoff, long-reset request, gap count[5:0]}. Address 4 = {link-active, contender, 3'b000, power class[2:0]}. Address 5 = {short-reset request, resume-interrupt enable, 6'b0}. Address 6 = 00h. Address 7 = {page[2:0], 5'b0}.
- R3: Constant fields read back fixed values. Address 2 reads {3'b111, 1'b0, port count[3:0]}, which is E6h for six ports. Address 3 reads {speed code 3'b010, 1'b0, repeater delay 4'b0}, which is 40h.
- R4: A write to addresses 0, 2, 3 or 6 has no effect. A write also has no effect on the jitter bits [5:3] of address 4, on the reserved bits of addresses 5 and 7, or on any paged address 8h–Fh.
- R5: Addresses 8h–Fh read through the selected page. On page 0, address 8h+k shows port k's status byte for k < port count, and 0 otherwise. On page 1, address 8h+k shows byte k of the identification word. Pages 2 through 7 read as 00h.
- R6: A single bus reset leaves the gap count unchanged. A second consecutive bus reset, with no gap-count write since the first, sets the gap count to 3Fh.
- R7: A gap-count write clears the consecutive bus-reset count. A gap-count write is a write to address 1 or a `cfg_gap_valid` pulse. When both arrive in the same cycle, the value from address 1 is taken.
- R8: A bus reset clears the long-reset and short-reset request bits. This happens even when a write sets either bit in the same cycle.
- R9: A bus reset does not change root-holdoff, resume-interrupt enable, link-active, contender, power class or page select.
- R10: The root bit is set by `root_set` and cleared by `bus_reset`. If both arrive in the same cycle, the bit is cleared. `cable_pwr` is shown live.
- R11: If a gap-count write and a bus reset arrive in the same cycle, the written value is kept, and that bus reset counts as the first one after the write. One further bus reset then restores 3Fh.
- R12: The read data follows `addr` and the current register state in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| addr | input | 4 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| bus_reset | input | 1 | One-cycle pulse per bus-reset event |
| cfg_gap_valid | input | 1 | Gap count delivered by a configuration packet |
| cfg_gap_value | input | 6 | Gap count value from the configuration packet |
| root_set | input | 1 | Tree identification made this node root |
| cable_pwr | input | 1 | Cable power present |
| phys_id | input | 6 | Physical ID from self-identification |
| port_status | input | NUM_PORTS*8 | One status byte per port, port 0 in the low byte |
| strap_contender | input | 1 | Contender default strap |
| strap_pwr_class | input | 3 | Power class default straps |
| gap_count | output | 6 | Current gap count |
| long_reset_req | output | 1 | Request for a long bus reset |
| short_reset_req | output | 1 | Request for a short arbitrated bus reset |
| root_holdoff | output | 1 | Try to become root after the next bus reset |
| link_active | output | 1 | Link-active control bit |
| contender | output | 1 | Contender bit |
| power_class | output | 3 | Power class field |

## Verification
Two functions can fall in the same cycle: a register write, and the effects of a bus reset. The bench creates these collisions on purpose. In one directed step, a bus reset pulse arrives in the same cycle as a write to the gap count. In another, it arrives with a write that sets a reset-request bit. Randomised traffic also lets writes, configuration-packet gap values, root indications and bus resets overlap freely. A behavioural model applies the stated priorities: the gap write is kept and counts one reset, the request bit is dropped, and root is cleared. Every cycle, the model's result is compared with the read data and the control outputs.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned GAP_W  = 6;
  localparam int unsigned PAGE_W = 3;
  localparam int unsigned BRC_W  = 2;

  localparam logic [GAP_W-1:0] GAP_DEFAULT = 6'h3F;
  localparam logic [2:0]       EXT_CODE    = 3'b111;
  localparam logic [2:0]       SPEED_CODE  = 3'b010;

  localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_IDENT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SPEED  = 4'd3;
  localparam logic [ADDR_W-1:0] A_LINK   = 4'd4;
  localparam logic [ADDR_W-1:0] A_AUX    = 4'd5;
  localparam logic [ADDR_W-1:0] A_RSVD   = 4'd6;
  localparam logic [ADDR_W-1:0] A_PAGE   = 4'd7;

  // Consecutive bus-reset count, saturating at 2.
  // A gap write in the same cycle as a bus reset counts as coming before it.
  function automatic logic [BRC_W-1:0] brc_next(input logic [BRC_W-1:0] cnt,
                                                input logic gap_wr,
                                                input logic bus_rst);
    if (bus_rst) begin
      if (gap_wr) return 2'd1;
      return (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;
    end
    if (gap_wr) return 2'd0;
    return cnt;
  endfunction

  function automatic logic gap_restore(input logic [BRC_W-1:0] cnt,
                                       input logic gap_wr,
                                       input logic bus_rst);
    return bus_rst && !gap_wr && (cnt != 2'd0);
  endfunction
endpackage

// File: rtl/prf_ctrl_regs.sv
module prf_ctrl_regs
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bus_reset_i,
  input  logic              cfg_gap_valid_i,
  input  logic [GAP_W-1:0]  cfg_gap_value_i,
  input  logic              root_set_i,
  input  logic              strap_contender_i,
  input  logic [2:0]        strap_pwr_class_i,
  output logic [GAP_W-1:0]  gap_q,
  output logic              rhb_q,
  output logic              ibr_q,
  output logic              isbr_q,
  output logic              rpie_q,
  output logic              lc_q,
  output logic              c_q,
  output logic [2:0]        pc_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              root_q
);
  logic [BRC_W-1:0] brc_q;

  // Named internal events
  logic wr_ctrl, wr_link, wr_aux, wr_page, gap_wr, restore_now;
  assign wr_ctrl     = wr_en_i && (addr_i == A_CTRL);
  assign wr_link     = wr_en_i && (addr_i == A_LINK);
  assign wr_aux      = wr_en_i && (addr_i == A_AUX);
  assign wr_page     = wr_en_i && (addr_i == A_PAGE);
  assign gap_wr      = wr_ctrl || cfg_gap_valid_i;
  assign restore_now = gap_restore(brc_q, gap_wr, bus_reset_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_DEFAULT;
      rhb_q  <= 1'b0;
      ibr_q  <= 1'b0;
      isbr_q <= 1'b0;
      rpie_q <= 1'b0;
      lc_q   <= 1'b1;
      c_q    <= strap_contender_i;
      pc_q   <= strap_pwr_class_i;
      page_q <= '0;
      root_q <= 1'b0;
      brc_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        rhb_q <= wr_data_i[7];
        ibr_q <= wr_data_i[6];
        gap_q <= wr_data_i[5:0];
      end else if (cfg_gap_valid_i) begin
        gap_q <= cfg_gap_value_i;
      end
      if (wr_link) begin
        lc_q <= wr_data_i[7];
        c_q  <= wr_data_i[6];
        pc_q <= wr_data_i[2:0];
      end
      if (wr_aux) begin
        isbr_q <= wr_data_i[7];
        rpie_q <= wr_data_i[6];
      end
      if (wr_page) page_q <= wr_data_i[7:5];
      if (root_set_i) root_q <= 1'b1;
      if (bus_reset_i) begin
        ibr_q  <= 1'b0;
        isbr_q <= 1'b0;
        root_q <= 1'b0;
        if (restore_now) gap_q <= GAP_DEFAULT;
      end
      brc_q <= brc_next(brc_q, gap_wr, bus_reset_i);
    end
  end

  // R6
  gap_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !gap_wr && brc_q != 2'd0) |=> (gap_q == GAP_DEFAULT));
  // R7
  brc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_wr && !bus_reset_i) |=> (brc_q == 2'd0));
  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (!ibr_q && !isbr_q));
  // R9
  holdoff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !wr_ctrl && !wr_aux) |=> ($stable(rhb_q) && $stable(rpie_q)));
  // R9
  link_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !wr_link && !wr_page) |=> $stable({lc_q, c_q, pc_q, page_q}));
  // R10
  root_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !root_q);
endmodule

// File: rtl/prf_read_mux.sv
module prf_read_mux
  import prf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter logic [63:0] ID_WORD   = 64'hA5C3_1E0F_7B24_9D68
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [GAP_W-1:0]       gap_i,
  input  logic                   rhb_i,
  input  logic                   ibr_i,
  input  logic                   isbr_i,
  input  logic                   rpie_i,
  input  logic                   lc_i,
  input  logic                   c_i,
  input  logic [2:0]             pc_i,
  input  logic [PAGE_W-1:0]      page_i,
  input  logic                   root_i,
  input  logic                   cable_pwr_i,
  input  logic [5:0]             phys_id_i,
  input  logic [NUM_PORTS*8-1:0] port_status_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  localparam int unsigned WIN = 8;
  localparam logic [3:0] PORT_CNT = 4'(NUM_PORTS);

  logic [DATA_W-1:0] port_byte [WIN];
  logic [DATA_W-1:0] id_byte   [WIN];

  for (genvar i = 0; i < WIN; i++) begin : g_win
    if (i < NUM_PORTS) begin : g_port
      assign port_byte[i] = port_status_i[8*i +: 8];
    end else begin : g_none
      assign port_byte[i] = '0;
    end
    assign id_byte[i] = ID_WORD[8*i +: 8];
  end

  logic [2:0] win_idx;
  assign win_idx = addr_i[2:0];

  always_comb begin
    rd_data_o = '0;
    if (!addr_i[3]) begin
      unique case (addr_i)
        A_STATUS: rd_data_o = {phys_id_i, root_i, cable_pwr_i};
        A_CTRL:   rd_data_o = {rhb_i, ibr_i, gap_i};
        A_IDENT:  rd_data_o = {EXT_CODE, 1'b0, PORT_CNT};
        A_SPEED:  rd_data_o = {SPEED_CODE, 1'b0, 4'b0000};
        A_LINK:   rd_data_o = {lc_i, c_i, 3'b000, pc_i};
        A_AUX:    rd_data_o = {isbr_i, rpie_i, 6'b0};
        A_PAGE:   rd_data_o = {page_i, 5'b0};
        default:  rd_data_o = '0;
      endcase
    end else begin
      unique case (page_i)
        3'd0:    rd_data_o = port_byte[win_idx];
        3'd1:    rd_data_o = id_byte[win_idx];
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import prf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter logic [63:0] ID_WORD   = 64'hA5C3_1E0F_7B24_9D68
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             addr,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  input  logic                   bus_reset,
  input  logic                   cfg_gap_valid,
  input  logic [5:0]             cfg_gap_value,
  input  logic                   root_set,
  input  logic                   cable_pwr,
  input  logic [5:0]             phys_id,
  input  logic [NUM_PORTS*8-1:0] port_status,
  input  logic                   strap_contender,
  input  logic [2:0]             strap_pwr_class,
  output logic [5:0]             gap_count,
  output logic                   long_reset_req,
  output logic                   short_reset_req,
  output logic                   root_holdoff,
  output logic                   link_active,
  output logic                   contender,
  output logic [2:0]             power_class
);
  logic [GAP_W-1:0]  gap_q;
  logic              rhb_q, ibr_q, isbr_q, rpie_q, lc_q, c_q, root_q;
  logic [2:0]        pc_q;
  logic [PAGE_W-1:0] page_q;

  prf_ctrl_regs u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .addr_i            (addr),
    .wr_en_i           (wr_en),
    .wr_data_i         (wr_data),
    .bus_reset_i       (bus_reset),
    .cfg_gap_valid_i   (cfg_gap_valid),
    .cfg_gap_value_i   (cfg_gap_value),
    .root_set_i        (root_set),
    .strap_contender_i (strap_contender),
    .strap_pwr_class_i (strap_pwr_class),
    .gap_q             (gap_q),
    .rhb_q             (rhb_q),
    .ibr_q             (ibr_q),
    .isbr_q            (isbr_q),
    .rpie_q            (rpie_q),
    .lc_q              (lc_q),
    .c_q               (c_q),
    .pc_q              (pc_q),
    .page_q            (page_q),
    .root_q            (root_q)
  );

  prf_read_mux #(.NUM_PORTS(NUM_PORTS), .ID_WORD(ID_WORD)) u_rd (
    .addr_i        (addr),
    .gap_i         (gap_q),
    .rhb_i         (rhb_q),
    .ibr_i         (ibr_q),
    .isbr_i        (isbr_q),
    .rpie_i        (rpie_q),
    .lc_i          (lc_q),
    .c_i           (c_q),
    .pc_i          (pc_q),
    .page_i        (page_q),
    .root_i        (root_q),
    .cable_pwr_i   (cable_pwr),
    .phys_id_i     (phys_id),
    .port_status_i (port_status),
    .rd_data_o     (rd_data)
  );

  assign gap_count       = gap_q;
  assign long_reset_req  = ibr_q;
  assign short_reset_req = isbr_q;
  assign root_holdoff    = rhb_q;
  assign link_active     = lc_q;
  assign contender       = c_q;
  assign power_class     = pc_q;

  // R5
  rsvd_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[3] && page_q >= 3'd2) |-> (rd_data == 8'h00));
  // R3
  ident_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SPEED) |-> (rd_data == 8'h40));
  // R4
  rsvd_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_RSVD) |-> (rd_data == 8'h00));
  // R12
  ctrl_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rd_data[5:0] == gap_count && rd_data[6] == long_reset_req));
endmodule

// File: tb/tb_phy_regfile.sv
module tb_phy_regfile;
  localparam int unsigned NP = 6;
  localparam logic [63:0] BID = 64'h1122_3344_5566_7788;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic bus_reset = 1'b0, cfg_gap_valid = 1'b0, root_set = 1'b0, cable_pwr = 1'b0;
  logic [5:0] cfg_gap_value = '0;
  logic [5:0] phys_id = 6'h2B;
  logic [NP*8-1:0] port_status = 48'h6655_4433_2211;
  logic strap_contender = 1'b1;
  logic [2:0] strap_pwr_class = 3'b101;
  logic [5:0] gap_count;
  logic long_reset_req, short_reset_req, root_holdoff, link_active, contender;
  logic [2:0] power_class;

  phy_regfile #(.NUM_PORTS(NP), .ID_WORD(BID)) dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  int m_gap, m_brc, m_pc, m_page;
  bit m_rhb, m_ibr, m_isbr, m_rpie, m_lc, m_c, m_root;

  function automatic void m_hw_reset();
    m_gap = 63; m_brc = 0; m_rhb = 0; m_ibr = 0; m_isbr = 0; m_rpie = 0;
    m_lc = 1; m_c = strap_contender; m_pc = strap_pwr_class; m_page = 0; m_root = 0;
  endfunction

  function automatic int exp_rd(input int a);
    int k;
    case (a)
      0: return phys_id * 4 + m_root * 2 + cable_pwr;
      1: return m_rhb * 128 + m_ibr * 64 + m_gap;
      2: return 8'hE6;
      3: return 8'h40;
      4: return m_lc * 128 + m_c * 64 + m_pc;
      5: return m_isbr * 128 + m_rpie * 64;
      6: return 0;
      7: return m_page * 32;
      default: begin
        k = a - 8;
        if (m_page == 0) return (k < NP) ? int'(port_status[8*k +: 8]) : 0;
        if (m_page == 1) return int'(BID[8*k +: 8]);
        return 0;
      end
    endcase
  endfunction

  function automatic void m_step(input int a, input bit we, input int wd, input bit br,
                                 input bit gv, input int gval, input bit rs);
    bit gw;
    gw = (we && a == 1) || gv;
    if (we && a == 1) begin m_rhb = wd[7]; m_ibr = wd[6]; m_gap = wd % 64; end
    else if (gv) m_gap = gval;
    if (we && a == 4) begin m_lc = wd[7]; m_c = wd[6]; m_pc = wd % 8; end
    if (we && a == 5) begin m_isbr = wd[7]; m_rpie = wd[6]; end
    if (we && a == 7) m_page = wd / 32;
    if (rs) m_root = 1;
    if (br) begin
      m_ibr = 0; m_isbr = 0; m_root = 0;
      if (!gw && m_brc >= 1) m_gap = 63;
      m_brc = gw ? 1 : ((m_brc >= 2) ? 2 : m_brc + 1);
    end else if (gw) m_brc = 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "gap_count", gap_count, m_gap);
    chk(tag, "reset_reqs", {long_reset_req, short_reset_req}, m_ibr * 2 + m_isbr);
    chk(tag, "holdoff", root_holdoff, m_rhb);
    chk(tag, "link_c_pc", {link_active, contender, power_class}, m_lc * 16 + m_c * 8 + m_pc);
  endtask

  // one clock: drive at negedge, check before posedge, model after posedge
  task automatic cyc(input int a, input bit we, input int wd, input bit br, input bit gv,
                     input int gval, input bit rs, input string tag);
    addr = 4'(a); wr_en = we; wr_data = 8'(wd); bus_reset = br;
    cfg_gap_valid = gv; cfg_gap_value = 6'(gval); root_set = rs;
    #5;
    chk(tag, $sformatf("rd_data@%0h", a), rd_data, exp_rd(a));
    check_outs(tag);
    @(posedge clk);
    m_step(a, we, wd, br, gv, gval, rs);
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(a, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cyc(a, 1, d, 0, 0, 0, 0, tag);
  endtask

  task automatic brst(input string tag);
    cyc(1, 0, 0, 1, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    m_hw_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R3 R5: reset state over all addresses, page 0
    for (int a = 0; a < 16; a++) rd(a, "R1_R2_R3_R5_reset");
    // R4: read-only registers ignore writes
    wr(0, 8'hFF, "R4"); rd(0, "R4");
    wr(2, 8'h00, "R4"); rd(2, "R4_R3");
    wr(3, 8'hFF, "R4"); rd(3, "R4_R3");
    wr(6, 8'hFF, "R4"); rd(6, "R4");
    wr(4, 8'h00, "R2"); rd(4, "R2");
    wr(4, 8'hFF, "R4"); rd(4, "R4_jitter");
    wr(5, 8'hFF, "R4"); rd(5, "R4_aux");
    wr(7, 8'hFF, "R4"); rd(7, "R4_page");
    // R5: pages
    wr(7, 8'h00, "R5");
    for (int a = 8; a < 16; a++) rd(a, "R5_page0");
    wr(8, 8'h5A, "R4_paged"); rd(8, "R4_paged");
    wr(7, 8'h20, "R5");
    for (int a = 8; a < 16; a++) rd(a, "R5_page1");
    wr(7, 8'h60, "R5"); rd(9, "R5_page3");
    wr(7, 8'hE0, "R5"); rd(12, "R5_page7");
    wr(7, 8'h00, "R5");
    // R12: read in same cycle as address change
    rd(1, "R12"); rd(4, "R12"); rd(0, "R12");
    // R6: gap restore after two resets
    wr(1, 8'h0A, "R6"); brst("R6_first"); rd(1, "R6_first");
    brst("R6_second"); rd(1, "R6_second");
    // R7: reg write beats packet, both clear count
    cyc(1, 1, 8'h05, 0, 1, 6'h12, 0, "R7_prio"); rd(1, "R7_prio");
    brst("R7"); cyc(1, 0, 0, 0, 1, 6'h20, 0, "R7_cfg");
    brst("R7_after_cfg"); rd(1, "R7_kept");
    brst("R7_second"); rd(1, "R7_restored");
    // R11: write and bus reset same cycle
    cyc(1, 1, 8'h07, 1, 0, 0, 0, "R11_collide"); rd(1, "R11_kept");
    brst("R11_next"); rd(1, "R11_restored");
    // R8 R9: request bits cleared, sticky bits kept
    wr(1, 8'hC9, "R8"); wr(5, 8'hC0, "R8"); wr(4, 8'h03, "R9"); wr(7, 8'h20, "R9");
    brst("R8_R9"); rd(1, "R8_R9"); rd(5, "R8_R9"); rd(4, "R9"); rd(7, "R9");
    wr(7, 8'h00, "R9");
    cyc(1, 1, 8'h41, 1, 0, 0, 0, "R8_collide"); rd(1, "R8_collide");
    cyc(5, 1, 8'h80, 1, 0, 0, 0, "R8_collide_s"); rd(5, "R8_collide_s");
    // R10: root and cable power
    cyc(0, 0, 0, 0, 0, 0, 1, "R10_set"); rd(0, "R10_set");
    cable_pwr = 1'b1; rd(0, "R10_cable");
    cyc(0, 0, 0, 1, 0, 0, 1, "R10_both"); rd(0, "R10_both");
    cable_pwr = 1'b0; rd(0, "R10_cable");
    // randomised overlap of all functions, checked every cycle (R6 R7 R8 R10 R11)
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cable_pwr = lfsr[9];
      cyc(int'(lfsr[3:0]) & ((lfsr[4]) ? 15 : 7), lfsr[5] & lfsr[6], int'(lfsr[15:8]),
          lfsr[7] & lfsr[2], lfsr[11] & lfsr[1], int'(lfsr[14:9]), lfsr[12] & lfsr[0],
          "R6_R7_R8_R10_R11_mix");
    end
    // R1: hardware reset again with other straps
    strap_contender = 1'b0; strap_pwr_class = 3'b010;
    rst_n = 1'b0; m_hw_reset();
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(a, "R1_rereset");
    finish_run();
  end
endmodule